// File: doc/BRIEF.md
# Image Sensor Power Sequencing Controller

This block sits on the host side of a camera link and brings an image sensor up and down safely. It drives the enables of the sensor's supply rails in a fixed order, starts the sensor's input clock, holds and then releases the sensor's active-low reset, waits out the sensor's internal start-up, and then asks for the register writes that configure the part and turn streaming on. The two-wire register traffic is handled elsewhere. This block only raises a request and waits for the matching done pulse.

Power-down runs the same steps in reverse. Streaming is cleared first. The block then waits for the sensor to report standby, which it reaches only once the row or frame in flight has ended. The clock is stopped, reset is asserted, and the rails drop from the last one enabled back to the first. A minimum off interval then has to pass before the rails may rise again. If a rail's power-good input does not assert in time, the controller runs the power-down sequence as a fault.

All time is counted on one free-running reference clock. `MS_TICKS` reference cycles make one millisecond. The post-reset initialisation wait is counted directly in input-clock cycles, and the input clock is taken to run at the reference rate.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, `rail_en` is all zero, `xclk_en` is 0, `sensor_rst_n` is 0, `cfg_req` and `str_req` are 0, and `phase` reads 0.
- R2: Rail enable bits rise strictly in index order. Bit 0 is the PLL supply, bit 1 the analog and pixel supplies together, bit 2 the I/O supply, bit 3 the core supply and bit 4 the high-speed serial supply. A rail is enabled only after the rail below it reports power-good, so the set of enabled rails is always a contiguous run starting at bit 0.
- R3: Between the power-good of one rail and the enable of the next, the controller waits `gap_ms` milliseconds. A `gap_ms` value of 0 gives no wait, and any value above `MAX_GAP_MS` (10) is treated as 10.
- R4: `xclk_en` rises only after the last rail has reported power-good, and it is high only while every rail is enabled.
- R5: `sensor_rst_n` stays low for `RESET_MS` milliseconds after `xclk_en` rises. It is high only while the clock is enabled.
- R6: `INIT_CYC` cycles after reset is released, `cfg_req` is raised. It is held until `cfg_done` is seen.
- R7: `PLL_MS` milliseconds after `cfg_done`, `str_req` is raised with `str_val` = 1, which asks for the streaming bit (bit 2 of the sensor's mode control register) to be set. When `str_done` arrives, `phase` reads streaming.
- R8: A `pwr_dn_req` while streaming first raises `str_req` with `str_val` = 0. After that, the rails and the clock stay unchanged until `stby_ack` is seen.
- R9: After `stby_ack`, `xclk_en` and `sensor_rst_n` go low, and the rails are disabled one at a time from the highest enabled index down to bit 0, with a `gap_ms` wait (clamped as in R3) between disables.
- R10: No rail is enabled until `OFF_MS` milliseconds after bit 0 is disabled. A `pwr_up_req` that arrives during that interval is held and serviced when the interval ends.
- R11: If the enabled rail's power-good does not assert within `PG_TO_MS` milliseconds, `phase` reads fault and the enabled rails are dropped as in R9. `phase` keeps reading fault through the off interval and reads off afterwards.
- R12: `phase` encodes the current activity as follows: 0 off, 1 ramping, 2 reset, 3 init, 4 configure, 5 PLL wait (which includes the stream-set write), 6 streaming, 7 stopping, 8 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| pwr_up_req | input | 1 | Request to start a power-up sequence |
| pwr_dn_req | input | 1 | Request to shut down, accepted while streaming |
| gap_ms | input | GAP_W | Wait in ms between consecutive rail steps |
| rail_pg | input | NUM_RAILS | Per-rail power-good, indexed like `rail_en` |
| rail_en | output | NUM_RAILS | Rail enables, bit 0 PLL up to bit 4 serial |
| xclk_en | output | 1 | Sensor input clock enable |
| sensor_rst_n | output | 1 | Active-low reset to the sensor |
| cfg_req | output | 1 | Request for the configuration register writes |
| cfg_done | input | 1 | Configuration writes finished |
| str_req | output | 1 | Request to write the streaming bit |
| str_val | output | 1 | Value to write into the streaming bit |
| str_done | input | 1 | Streaming bit write finished |
| stby_ack | input | 1 | Sensor has reached standby |
| phase | output | 4 | Current phase code (R12) |

## Verification
The bench builds the block with `MS_TICKS` = 10, `INIT_CYC` = 40, `RESET_MS` = 2, `PLL_MS` = 3, `PG_TO_MS` = 5 and `OFF_MS` = 100. `MAX_GAP_MS` stays at 10 and `gap_ms` stays 4 bits wide. With these values every millisecond delay, the 100 ms off interval and the power-good timeout finish within a few hundred to a thousand cycles. Each delay can therefore be measured from edge to edge and compared against its own parameter. Because the gap field is still 4 bits wide, the bench can drive the over-range value 15 and observe the clamp to 10. The values 0, 1 and 2 cover the zero-wait and short-wait cases.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [3:0] {
      PH_OFF     = 4'd0,
      PH_RAMP    = 4'd1,
      PH_RESET   = 4'd2,
      PH_INIT    = 4'd3,
      PH_CONFIG  = 4'd4,
      PH_PLLWAIT = 4'd5,
      PH_STREAM  = 4'd6,
      PH_STOP    = 4'd7,
      PH_FAULT   = 4'd8
   } phase_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrseq_timer.sv
// Single down-counter used for every wait. It counts either raw cycles or
// milliseconds; the ms prescaler restarts on every load so delays are exact.
module pwrseq_timer #(
   parameter int unsigned CNT_W    = 18,
   parameter int unsigned MS_TICKS = 50000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_ms,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;
   logic             ms_mode_q;
   logic             tick;

   generate
      if (MS_TICKS == 1) begin : g_notick
         assign tick = 1'b1;
      end else begin : g_presc
         localparam int unsigned PRE_W = $clog2(MS_TICKS);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_TICKS - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (load) begin
               pre_q <= '0;
            end else if (cnt_q != '0) begin
               if (pre_q == PRE_LAST) pre_q <= '0;
               else                   pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         ms_mode_q <= 1'b0;
      end else if (load) begin
         cnt_q     <= load_val;
         ms_mode_q <= load_ms;
      end else if ((cnt_q != '0) && (!ms_mode_q || tick)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_railbank.sv
// One enable flop per rail; the sequencer addresses a rail by index.
module pwrseq_railbank #(
   parameter int unsigned NUM_RAILS = 5,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_stb,
   input  logic                 clr_stb,
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_RAILS-1:0] en
);

   generate
      for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
         logic on_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               on_q <= 1'b0;
            end else if (set_stb && (idx == IDX_W'(i))) begin
               on_q <= 1'b1;
            end else if (clr_stb && (idx == IDX_W'(i))) begin
               on_q <= 1'b0;
            end
         end
         assign en[i] = on_q;
      end
   endgenerate

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
#(
   parameter int unsigned NUM_RAILS  = 5,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned CNT_W      = 18,
   parameter int unsigned GAP_W      = 4,
   parameter int unsigned MAX_GAP_MS = 10,
   parameter int unsigned RESET_MS   = 1,
   parameter int unsigned INIT_CYC   = 150000,
   parameter int unsigned PLL_MS     = 1,
   parameter int unsigned OFF_MS     = 100,
   parameter int unsigned PG_TO_MS   = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_up_req,
   input  logic                 pwr_dn_req,
   input  logic [GAP_W-1:0]     gap_ms,
   input  logic [NUM_RAILS-1:0] rail_pg,
   input  logic                 cfg_done,
   input  logic                 str_done,
   input  logic                 stby_ack,
   input  logic                 tmr_expired,
   output logic                 tmr_load,
   output logic                 tmr_load_ms,
   output logic [CNT_W-1:0]     tmr_val,
   output logic                 rail_set,
   output logic                 rail_clr,
   output logic [IDX_W-1:0]     rail_idx,
   output logic                 xclk_en,
   output logic                 sensor_rst_n,
   output logic                 cfg_req,
   output logic                 str_req,
   output logic                 str_val,
   output phase_e               phase
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RAILS - 1);
   localparam logic [GAP_W-1:0] GAP_CAP  = GAP_W'(MAX_GAP_MS);

   typedef enum logic [3:0] {
      S_IDLE, S_RAILON, S_PGWAIT, S_GAP, S_RST, S_INIT, S_CFG,
      S_PLL, S_STRON, S_RUN, S_STROFF, S_STBY, S_DROP, S_DNGAP, S_COOL
   } state_e;

   state_e           state_q, state_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             fault_q, fault_d;
   logic             pend_q, pend_d;
   logic             xclk_q, xclk_d;
   logic             rstn_q, rstn_d;
   logic [GAP_W-1:0] gap_eff;

   assign gap_eff = (gap_ms > GAP_CAP) ? GAP_CAP : gap_ms;

   always_comb begin
      state_d     = state_q;
      idx_d       = idx_q;
      fault_d     = fault_q;
      pend_d      = pend_q;
      xclk_d      = xclk_q;
      rstn_d      = rstn_q;
      tmr_load    = 1'b0;
      tmr_load_ms = 1'b1;
      tmr_val     = '0;
      rail_set    = 1'b0;
      rail_clr    = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (pwr_up_req || pend_q) begin
               pend_d  = 1'b0;
               idx_d   = '0;
               state_d = S_RAILON;
            end
         end
         S_RAILON: begin
            rail_set = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PG_TO_MS);
            state_d  = S_PGWAIT;
         end
         S_PGWAIT: begin
            if (rail_pg[idx_q]) begin
               tmr_load = 1'b1;
               if (idx_q == LAST_IDX) begin
                  xclk_d  = 1'b1;
                  tmr_val = CNT_W'(RESET_MS);
                  state_d = S_RST;
               end else begin
                  idx_d   = idx_q + 1'b1;
                  tmr_val = CNT_W'(gap_eff);
                  state_d = S_GAP;
               end
            end else if (tmr_expired) begin
               fault_d = 1'b1;
               xclk_d  = 1'b0;
               rstn_d  = 1'b0;
               state_d = S_DROP;
            end
         end
         S_GAP: begin
            if (tmr_expired) state_d = S_RAILON;
         end
         S_RST: begin
            if (tmr_expired) begin
               rstn_d      = 1'b1;
               tmr_load    = 1'b1;
               tmr_load_ms = 1'b0;
               tmr_val     = CNT_W'(INIT_CYC);
               state_d     = S_INIT;
            end
         end
         S_INIT: begin
            if (tmr_expired) state_d = S_CFG;
         end
         S_CFG: begin
            if (cfg_done) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PLL_MS);
               state_d  = S_PLL;
            end
         end
         S_PLL: begin
            if (tmr_expired) state_d = S_STRON;
         end
         S_STRON: begin
            if (str_done) state_d = S_RUN;
         end
         S_RUN: begin
            if (pwr_dn_req) state_d = S_STROFF;
         end
         S_STROFF: begin
            if (str_done) state_d = S_STBY;
         end
         S_STBY: begin
            if (stby_ack) begin
               xclk_d  = 1'b0;
               rstn_d  = 1'b0;
               idx_d   = LAST_IDX;
               state_d = S_DROP;
            end
         end
         S_DROP: begin
            rail_clr = 1'b1;
            tmr_load = 1'b1;
            if (idx_q == '0) begin
               tmr_val = CNT_W'(OFF_MS);
               state_d = S_COOL;
            end else begin
               tmr_val = CNT_W'(gap_eff);
               state_d = S_DNGAP;
            end
         end
         S_DNGAP: begin
            if (tmr_expired) begin
               idx_d   = idx_q - 1'b1;
               state_d = S_DROP;
            end
         end
         S_COOL: begin
            if (pwr_up_req) pend_d = 1'b1;
            if (tmr_expired) begin
               fault_d = 1'b0;
               state_d = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         fault_q <= 1'b0;
         pend_q  <= 1'b0;
         xclk_q  <= 1'b0;
         rstn_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         fault_q <= fault_d;
         pend_q  <= pend_d;
         xclk_q  <= xclk_d;
         rstn_q  <= rstn_d;
      end
   end

   always_comb begin
      unique case (state_q)
         S_IDLE:                       phase = PH_OFF;
         S_RAILON, S_PGWAIT, S_GAP:    phase = PH_RAMP;
         S_RST:                        phase = PH_RESET;
         S_INIT:                       phase = PH_INIT;
         S_CFG:                        phase = PH_CONFIG;
         S_PLL, S_STRON:               phase = PH_PLLWAIT;
         S_RUN:                        phase = PH_STREAM;
         S_STROFF, S_STBY:             phase = PH_STOP;
         S_DROP, S_DNGAP:              phase = fault_q ? PH_FAULT : PH_STOP;
         S_COOL:                       phase = fault_q ? PH_FAULT : PH_OFF;
         default:                      phase = PH_OFF;
      endcase
   end

   assign rail_idx     = idx_q;
   assign xclk_en      = xclk_q;
   assign sensor_rst_n = rstn_q;
   assign cfg_req      = (state_q == S_CFG);
   assign str_req      = (state_q == S_STRON) || (state_q == S_STROFF);
   assign str_val      = (state_q == S_STRON);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter int unsigned NUM_RAILS  = 5,
   parameter int unsigned MS_TICKS   = 50000,
   parameter int unsigned GAP_W      = 4,
   parameter int unsigned MAX_GAP_MS = 10,
   parameter int unsigned RESET_MS   = 1,
   parameter int unsigned INIT_CYC   = 150000,
   parameter int unsigned PLL_MS     = 1,
   parameter int unsigned OFF_MS     = 100,
   parameter int unsigned PG_TO_MS   = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_up_req,
   input  logic                 pwr_dn_req,
   input  logic [GAP_W-1:0]     gap_ms,
   input  logic [NUM_RAILS-1:0] rail_pg,
   output logic [NUM_RAILS-1:0] rail_en,
   output logic                 xclk_en,
   output logic                 sensor_rst_n,
   output logic                 cfg_req,
   input  logic                 cfg_done,
   output logic                 str_req,
   output logic                 str_val,
   input  logic                 str_done,
   input  logic                 stby_ack,
   output logic [3:0]           phase
);

   localparam int unsigned IDX_W   = $clog2(NUM_RAILS);
   localparam int unsigned LONGEST = umax(umax(umax(INIT_CYC, OFF_MS), umax(PG_TO_MS, RESET_MS)),
                                          umax(PLL_MS, MAX_GAP_MS));
   localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

   generate
      if (NUM_RAILS < 2) begin : g_bad_rails
         $error("pwrseq_ctrl: NUM_RAILS must be at least 2");
      end
      if (MS_TICKS < 1) begin : g_bad_tick
         $error("pwrseq_ctrl: MS_TICKS must be at least 1");
      end
      if (MAX_GAP_MS >= (1 << GAP_W)) begin : g_bad_gap
         $error("pwrseq_ctrl: MAX_GAP_MS does not fit in GAP_W bits");
      end
   endgenerate

   logic             tmr_load, tmr_load_ms, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             rail_set, rail_clr;
   logic [IDX_W-1:0] rail_idx;
   phase_e           phase_s;

   pwrseq_fsm #(
      .NUM_RAILS (NUM_RAILS),
      .IDX_W     (IDX_W),
      .CNT_W     (CNT_W),
      .GAP_W     (GAP_W),
      .MAX_GAP_MS(MAX_GAP_MS),
      .RESET_MS  (RESET_MS),
      .INIT_CYC  (INIT_CYC),
      .PLL_MS    (PLL_MS),
      .OFF_MS    (OFF_MS),
      .PG_TO_MS  (PG_TO_MS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwr_up_req  (pwr_up_req),
      .pwr_dn_req  (pwr_dn_req),
      .gap_ms      (gap_ms),
      .rail_pg     (rail_pg),
      .cfg_done    (cfg_done),
      .str_done    (str_done),
      .stby_ack    (stby_ack),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_load_ms (tmr_load_ms),
      .tmr_val     (tmr_val),
      .rail_set    (rail_set),
      .rail_clr    (rail_clr),
      .rail_idx    (rail_idx),
      .xclk_en     (xclk_en),
      .sensor_rst_n(sensor_rst_n),
      .cfg_req     (cfg_req),
      .str_req     (str_req),
      .str_val     (str_val),
      .phase       (phase_s)
   );

   pwrseq_timer #(
      .CNT_W   (CNT_W),
      .MS_TICKS(MS_TICKS)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_ms (tmr_load_ms),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   pwrseq_railbank #(
      .NUM_RAILS(NUM_RAILS),
      .IDX_W    (IDX_W)
   ) u_rails (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_stb(rail_set),
      .clr_stb(rail_clr),
      .idx    (rail_idx),
      .en     (rail_en)
   );

   assign phase = phase_s;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
   import pwrseq_pkg::*;
#(
   parameter int unsigned NUM_RAILS = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_RAILS-1:0] rail_en,
   input logic                 xclk_en,
   input logic                 sensor_rst_n,
   input logic                 cfg_req,
   input logic                 str_req,
   input logic [3:0]           phase
);

   // R2
   rail_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rail_en + 1'b1) & rail_en) == '0);

   // R9
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rail_en ^ $past(rail_en)) <= 1);

   // R4
   clk_needs_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xclk_en |-> (&rail_en));

   // R5
   rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sensor_rst_n |-> xclk_en);

   // R7
   str_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      str_req |-> (sensor_rst_n && xclk_en && !cfg_req));

   // R7
   stream_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STREAM) |-> ((&rail_en) && xclk_en && sensor_rst_n));

   // R11
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FAULT) |-> (!xclk_en && !sensor_rst_n));

   // R12
   phase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= 4'd8);

endmodule

bind pwrseq_ctrl pwrseq_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rail_en     (rail_en),
   .xclk_en     (xclk_en),
   .sensor_rst_n(sensor_rst_n),
   .cfg_req     (cfg_req),
   .str_req     (str_req),
   .phase       (phase)
);

// File: tb/sim_pwrseq_ctrl.sv
module sim_pwrseq_ctrl;

   localparam int MS   = 10;
   localparam int INIT = 40;
   localparam int RSTM = 2;
   localparam int PLLM = 3;
   localparam int OFFM = 100;
   localparam int PGTO = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_up_req = 1'b0;
   logic       pwr_dn_req = 1'b0;
   logic [3:0] gap_ms = 4'd0;
   logic [4:0] rail_pg = 5'd0;
   logic [4:0] rail_en;
   logic       xclk_en, sensor_rst_n, cfg_req, str_req, str_val;
   logic       cfg_done = 1'b0;
   logic       str_done = 1'b0;
   logic       stby_ack = 1'b0;
   logic [3:0] phase;
   logic [4:0] stuck = 5'd0;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwrseq_ctrl #(
      .NUM_RAILS(5), .MS_TICKS(MS), .GAP_W(4), .MAX_GAP_MS(10),
      .RESET_MS(RSTM), .INIT_CYC(INIT), .PLL_MS(PLLM), .OFF_MS(OFFM), .PG_TO_MS(PGTO)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
      .gap_ms(gap_ms), .rail_pg(rail_pg), .rail_en(rail_en), .xclk_en(xclk_en),
      .sensor_rst_n(sensor_rst_n), .cfg_req(cfg_req), .cfg_done(cfg_done),
      .str_req(str_req), .str_val(str_val), .str_done(str_done),
      .stby_ack(stby_ack), .phase(phase)
   );

   // supply and register-bus models
   initial begin
      forever begin
         @(negedge clk);
         rail_pg  <= rail_en & ~stuck;
         cfg_done <= cfg_req && !cfg_done;
         str_done <= str_req && !str_done;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_win(input int act, input int lo, input int slack, input string tag);
      check((act >= lo) && (act <= lo + slack), tag, act, lo);
   endtask

   task automatic pulse_up();
      @(negedge clk) pwr_up_req = 1'b1;
      @(negedge clk) pwr_up_req = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(rail_en == 5'd0, "R1 rails off", rail_en, 0);
      check(!xclk_en && !sensor_rst_n, "R1 clock off, reset low", {xclk_en, sensor_rst_n}, 0);
      check(!cfg_req && !str_req, "R1 no bus requests", {cfg_req, str_req}, 0);
      check(phase == 4'd0, "R1 phase off", phase, 0);
   endtask

   task automatic t_powerup(input int g_set, input int g_exp, input bit do_req);
      int t_r[5];
      int t0;
      gap_ms = 4'(g_set);
      if (do_req) pulse_up();
      for (int i = 0; i < 5; i++) begin
         while (!rail_en[i]) @(negedge clk);
         t_r[i] = cyc;
         check((rail_en >> (i + 1)) == 0, "R2 rail order on", rail_en, (1 << (i + 1)) - 1);
         if (i > 0) check_win(t_r[i] - t_r[i-1], g_exp * MS, 6, "R3 rail gap");
         if (i == 1) check(phase == 4'd1, "R12 ramp phase", phase, 1);
      end
      while (!xclk_en) @(negedge clk);
      t0 = cyc;
      check(rail_en == 5'h1f, "R4 clock after all rails", rail_en, 31);
      check(!sensor_rst_n, "R5 reset low at clock start", sensor_rst_n, 0);
      check(phase == 4'd2, "R12 reset phase", phase, 2);
      while (!sensor_rst_n) @(negedge clk);
      check_win(cyc - t0, RSTM * MS, 5, "R5 reset low time");
      check(phase == 4'd3, "R12 init phase", phase, 3);
      t0 = cyc;
      while (!cfg_req) @(negedge clk);
      check_win(cyc - t0, INIT, 5, "R6 init cycles");
      check(phase == 4'd4, "R12 configure phase", phase, 4);
      t0 = cyc;
      while (!str_req) @(negedge clk);
      check_win(cyc - t0, PLLM * MS, 5, "R7 PLL wait");
      check(str_val == 1'b1, "R7 stream set value", str_val, 1);
      check(phase == 4'd5, "R12 PLL wait phase", phase, 5);
      while (phase != 4'd6) @(negedge clk);
      check(xclk_en && sensor_rst_n && (rail_en == 5'h1f), "R7 streaming state",
            {xclk_en, sensor_rst_n, rail_en}, 127);
   endtask

   task automatic t_powerdown(input int g_exp, output int t_off);
      int t_f[5];
      @(negedge clk) pwr_dn_req = 1'b1;
      @(negedge clk) pwr_dn_req = 1'b0;
      while (!str_req) @(negedge clk);
      check(str_val == 1'b0, "R8 stream clear first", str_val, 0);
      repeat (30) @(negedge clk);
      check(rail_en == 5'h1f && xclk_en, "R8 hold until standby", rail_en, 31);
      check(phase == 4'd7, "R12 stopping phase", phase, 7);
      stby_ack = 1'b1;
      for (int i = 4; i >= 0; i--) begin
         while (rail_en[i]) @(negedge clk);
         t_f[i] = cyc;
         if (i == 4) begin
            stby_ack = 1'b0;
            check(!xclk_en && !sensor_rst_n, "R9 clock off before rails", {xclk_en, sensor_rst_n}, 0);
         end
         check(rail_en == 5'((1 << i) - 1), "R9 reverse order", rail_en, (1 << i) - 1);
         if (i < 4) check_win(t_f[i] - t_f[i+1], g_exp * MS, 5, "R9 drop gap");
      end
      t_off = t_f[0];
   endtask

   task automatic t_offinterval(input int t_off);
      gap_ms = 4'd15;
      repeat (50) @(negedge clk);
      pulse_up();
      repeat (400) @(negedge clk);
      check(rail_en == 5'd0, "R10 no rail during off interval", rail_en, 0);
      check(phase == 4'd0, "R12 off phase in interval", phase, 0);
      while (!rail_en[0]) @(negedge clk);
      check_win(cyc - t_off, OFFM * MS, 5, "R10 pending request served after interval");
   endtask

   task automatic t_fault();
      int t0;
      stuck  = 5'b00100;
      gap_ms = 4'd1;
      pulse_up();
      while (!rail_en[2]) @(negedge clk);
      t0 = cyc;
      while (phase != 4'd8) @(negedge clk);
      check_win(cyc - t0, PGTO * MS, 5, "R11 power-good timeout");
      check(rail_en[4:3] == 2'b00, "R11 no rail past failed one", rail_en, 7);
      while (rail_en[2]) @(negedge clk);
      check(rail_en == 5'b00011, "R11 failed rail dropped first", rail_en, 3);
      t0 = cyc;
      while (rail_en[1]) @(negedge clk);
      check(rail_en == 5'b00001, "R11 reverse drop", rail_en, 1);
      check_win(cyc - t0, MS, 5, "R11 drop gap");
      while (rail_en[0]) @(negedge clk);
      t0 = cyc;
      repeat (100) @(negedge clk);
      check(phase == 4'd8, "R11 fault shown in off interval", phase, 8);
      while (phase != 4'd0) @(negedge clk);
      check_win(cyc - t0, OFFM * MS, 5, "R11 fault clears after interval");
      stuck = 5'd0;
   endtask

   initial begin
      int t_off;
      t_reset();
      t_powerup(2, 2, 1'b1);
      t_powerdown(2, t_off);
      t_offinterval(t_off);
      t_powerup(15, 10, 1'b0);
      t_powerdown(10, t_off);
      t_fault();
      t_powerup(0, 0, 1'b1);
      t_powerdown(0, t_off);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule